// File: doc/BRIEF.md
# Dual-Buffer Frame Transmit Controller

This block is the transmit half of a small Ethernet MAC as seen from a processor. It holds two frame buffers on a 32-bit word-addressed register port. Each buffer has its own length word and its own control/status word. Software fills a buffer with frame bytes and writes the byte count. It then sets the start bit in that buffer's status word. The block sends the buffer's bytes over a byte-wide valid/ready stream and clears the start bit once the last byte has been accepted. Preamble, FCS and the PHY side are handled elsewhere.

The same start bit, written together with a second command bit, does a different job. Instead of sending a frame, the block copies the first six bytes of the buffer into a 48-bit station address register. Every status word also carries a scratch bit that belongs to software alone. A completion interrupt is raised only when both that buffer's enable and the global enable are set.

Top module: `txb_ctrl`

## Requirements
- R1: After reset, both status words, both length words and the global enable read 0. The station address is 0, and `irq` and `tx_valid` are low.
- R2: Address map. Word address bit 9 selects the buffer. Within a buffer, words 0..508 (byte offsets 0x000-0x7F3) are frame data and read back as written. Word 509 (0x7F4) is the length, with bits 15:0 stored and the upper bits reading 0. Word 510 (0x7F8) holds the global interrupt enable in bit 31 and is shared by both buffers. Word 511 (0x7FC) is the status word.
- R3: Writing status bit 0 = 1 to an idle buffer sets it busy. The buffer's bytes are then streamed from the lowest address upward, little-endian within each 32-bit word (bits 7:0 first). `tx_last` is high on the final byte. After the last handshake, bit 0 reads 0.
- R4: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold their values.
- R5: A buffer started while the other is being sent is transmitted after the running frame completes. If both are pending at once, buffer 0 goes first.
- R6: The number of bytes sent is the length word clamped to 2036. A length of 0 sends no byte and clears bit 0 straight away.
- R7: Writing bits 0 and 1 together loads the buffer's first six bytes into the station address, with byte 0 landing in bits 47:40. No byte is streamed, and both bits read 0 once the load is done.
- R8: Writing bit 1 without bit 0 has no effect. The status word keeps bit 1 at 0 and nothing is sent.
- R9: Status bit 31 is a scratch bit. It reads back what was last written and is never changed by the hardware, including at completion.
- R10: `irq` is a one-cycle pulse in the cycle after a buffer's bit 0 falls. It fires only if that buffer's bit 3 (interrupt enable) and the global enable are both 1.
- R11: Writes to bits 0 and 1 of a busy buffer are ignored. The bits cannot be cleared by software, and the frame is sent exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register port write strobe |
| bus_addr | input | 10 | Word address (bit 9 = buffer) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| tx_data | output | 8 | Outgoing frame byte |
| tx_valid | output | 1 | Byte valid |
| tx_ready | input | 1 | Sink accepts the byte |
| tx_last | output | 1 | Final byte of the frame |
| station_addr | output | 48 | Loaded station address |
| irq | output | 1 | Completion interrupt pulse |

## Verification
The bench stalls the sink in the middle of a frame and then writes the busy buffer's status word. A design that let software clear bit 0 would either truncate the frame or send it twice. It starts the second buffer while the first is still held by back-pressure, to catch a design that interleaves bytes or serves buffers out of order. It sends lengths of 0 and above the 2036-byte data area. An unclamped design would stream register words as data, and one that mishandles zero would hang or emit a stray byte. It also checks the station load for byte order and for leaked stream bytes, the scratch bit across completion, and interrupt gating under each enable combination.

// File: rtl/txb_pkg.sv
package txb_pkg;

    // Status word bit positions; software depends on them.
    localparam int ST_BUSY = 0;
    localparam int ST_PROG = 1;
    localparam int ST_IE   = 3;
    localparam int ST_SCR  = 31;

    localparam int STATION_BYTES = 6;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_SEND,
        ENG_LOAD
    } eng_state_t;

    typedef struct packed {
        logic scratch;
        logic ie;
        logic prog;
        logic busy;
    } stat_t;

    function automatic logic [31:0] pack_stat(stat_t s);
        logic [31:0] r;
        r          = '0;
        r[ST_SCR]  = s.scratch;
        r[ST_IE]   = s.ie;
        r[ST_PROG] = s.prog;
        r[ST_BUSY] = s.busy;
        return r;
    endfunction

    function automatic logic [15:0] clamp_len(logic [15:0] l, logic [15:0] cap);
        return (l > cap) ? cap : l;
    endfunction

endpackage

// File: rtl/txb_mem.sv
module txb_mem #(
    parameter int AW = 10,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [DW-1:0] rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [DW-1:0] rdata_b
);
    localparam int DEPTH = 2 ** AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/txb_regs.sv
module txb_regs
    import txb_pkg::*;
#(
    parameter int BANK_AW = 9
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [BANK_AW:0]   addr,
    input  logic [15:0]        wr_len,
    input  stat_t              wr_stat,
    input  logic               done,
    input  logic               done_bank,
    output stat_t [1:0]        stat,
    output logic [1:0][15:0]   len,
    output logic               gie,
    output logic               irq,
    output logic [31:0]        rdata
);
    localparam int WORDS = 2 ** BANK_AW;
    localparam logic [BANK_AW-1:0] LEN_IDX  = BANK_AW'(WORDS - 3);
    localparam logic [BANK_AW-1:0] GIE_IDX  = BANK_AW'(WORDS - 2);
    localparam logic [BANK_AW-1:0] STAT_IDX = BANK_AW'(WORDS - 1);

    logic               bank;
    logic [BANK_AW-1:0] idx;

    assign bank = addr[BANK_AW];
    assign idx  = addr[BANK_AW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            stat <= '0;
            len  <= '0;
            gie  <= 1'b0;
            irq  <= 1'b0;
        end else begin
            irq <= done && stat[done_bank].ie && gie;
            if (we) begin
                if (idx == LEN_IDX) begin
                    len[bank] <= wr_len;
                end else if (idx == GIE_IDX) begin
                    gie <= wr_stat.scratch;
                end else if (idx == STAT_IDX) begin
                    stat[bank].ie      <= wr_stat.ie;
                    stat[bank].scratch <= wr_stat.scratch;
                    if (!stat[bank].busy && wr_stat.busy) begin
                        stat[bank].busy <= 1'b1;
                        stat[bank].prog <= wr_stat.prog;
                    end
                end
            end
            if (done) begin
                stat[done_bank].busy <= 1'b0;
                stat[done_bank].prog <= 1'b0;
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (idx == LEN_IDX)       rdata = {16'h0000, len[bank]};
        else if (idx == GIE_IDX)  rdata = {gie, 31'h0};
        else if (idx == STAT_IDX) rdata = pack_stat(stat[bank]);
    end
endmodule

// File: rtl/txb_engine.sv
module txb_engine
    import txb_pkg::*;
#(
    parameter int BANK_AW    = 9,
    parameter int DATA_BYTES = 2036
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        busy,
    input  logic [1:0]        prog,
    input  logic [1:0][15:0]  len,
    input  logic [31:0]       rd_word,
    output logic [BANK_AW:0]  rd_addr,
    input  logic              tx_ready,
    output logic [7:0]        tx_data,
    output logic              tx_valid,
    output logic              tx_last,
    output logic [47:0]       station,
    output logic              done,
    output logic              done_bank
);
    localparam logic [15:0] CAP       = 16'(DATA_BYTES);
    localparam logic [15:0] LOAD_LAST = 16'(STATION_BYTES - 1);

    eng_state_t  state_q;
    logic        bank_q;
    logic [15:0] cnt_q;
    logic [15:0] elen_q;

    logic        any_pend;
    logic        pick;
    logic [15:0] pick_len;
    logic [31:0] shifted;
    logic [7:0]  cur_byte;

    assign any_pend = |busy;
    assign pick     = busy[0] ? 1'b0 : 1'b1;
    assign pick_len = clamp_len(len[pick], CAP);

    assign rd_addr  = {bank_q, cnt_q[BANK_AW+1:2]};
    assign shifted  = rd_word >> {cnt_q[1:0], 3'b000};
    assign cur_byte = shifted[7:0];

    assign tx_valid = (state_q == ENG_SEND);
    assign tx_data  = cur_byte;
    assign tx_last  = tx_valid && (cnt_q == elen_q - 16'd1);

    always_comb begin
        done      = 1'b0;
        done_bank = bank_q;
        unique case (state_q)
            ENG_IDLE: begin
                if (any_pend && !prog[pick] && pick_len == 16'd0) begin
                    done      = 1'b1;
                    done_bank = pick;
                end
            end
            ENG_SEND: done = tx_ready && tx_last;
            ENG_LOAD: done = (cnt_q == LOAD_LAST);
            default:  done = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ENG_IDLE;
            bank_q  <= 1'b0;
            cnt_q   <= '0;
            elen_q  <= '0;
            station <= '0;
        end else begin
            unique case (state_q)
                ENG_IDLE: begin
                    if (any_pend) begin
                        bank_q <= pick;
                        cnt_q  <= '0;
                        elen_q <= pick_len;
                        if (prog[pick])              state_q <= ENG_LOAD;
                        else if (pick_len != 16'd0)  state_q <= ENG_SEND;
                    end
                end
                ENG_SEND: begin
                    if (tx_ready) begin
                        if (tx_last) state_q <= ENG_IDLE;
                        else         cnt_q   <= cnt_q + 16'd1;
                    end
                end
                ENG_LOAD: begin
                    station <= {station[39:0], cur_byte};
                    if (cnt_q == LOAD_LAST) state_q <= ENG_IDLE;
                    else                    cnt_q   <= cnt_q + 16'd1;
                end
                default: state_q <= ENG_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/txb_ctrl.sv
module txb_ctrl
    import txb_pkg::*;
#(
    parameter int BANK_AW = 9
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_we,
    input  logic [BANK_AW:0]    bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic [7:0]          tx_data,
    output logic                tx_valid,
    input  logic                tx_ready,
    output logic                tx_last,
    output logic [47:0]         station_addr,
    output logic                irq
);
    localparam int WORDS      = 2 ** BANK_AW;
    localparam int DATA_WORDS = WORDS - 3;
    localparam int DATA_BYTES = DATA_WORDS * 4;
    localparam logic [BANK_AW-1:0] FIRST_REG = BANK_AW'(DATA_WORDS);

    stat_t [1:0]       stat;
    logic [1:0][15:0]  len;
    logic              gie;
    logic [1:0]        busy_v;
    logic [1:0]        prog_v;
    logic [1:0]        scr_v;
    logic              is_reg;
    logic [31:0]       reg_rdata;
    logic [31:0]       mem_rdata;
    logic [31:0]       eng_word;
    logic [BANK_AW:0]  eng_addr;
    logic              done;
    logic              done_bank;
    stat_t             wr_stat;

    assign is_reg = (bus_addr[BANK_AW-1:0] >= FIRST_REG);

    assign wr_stat.scratch = bus_wdata[ST_SCR];
    assign wr_stat.ie      = bus_wdata[ST_IE];
    assign wr_stat.prog    = bus_wdata[ST_PROG];
    assign wr_stat.busy    = bus_wdata[ST_BUSY];

    for (genvar b = 0; b < 2; b++) begin : g_bits
        assign busy_v[b] = stat[b].busy;
        assign prog_v[b] = stat[b].prog;
        assign scr_v[b]  = stat[b].scratch;
    end

    txb_mem #(.AW(BANK_AW + 1), .DW(32)) u_mem (
        .clk     (clk),
        .we      (bus_we && !is_reg),
        .waddr   (bus_addr),
        .wdata   (bus_wdata),
        .raddr_a (bus_addr),
        .rdata_a (mem_rdata),
        .raddr_b (eng_addr),
        .rdata_b (eng_word)
    );

    txb_regs #(.BANK_AW(BANK_AW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .we        (bus_we),
        .addr      (bus_addr),
        .wr_len    (bus_wdata[15:0]),
        .wr_stat   (wr_stat),
        .done      (done),
        .done_bank (done_bank),
        .stat      (stat),
        .len       (len),
        .gie       (gie),
        .irq       (irq),
        .rdata     (reg_rdata)
    );

    txb_engine #(.BANK_AW(BANK_AW), .DATA_BYTES(DATA_BYTES)) u_eng (
        .clk       (clk),
        .rst       (rst),
        .busy      (busy_v),
        .prog      (prog_v),
        .len       (len),
        .rd_word   (eng_word),
        .rd_addr   (eng_addr),
        .tx_ready  (tx_ready),
        .tx_data   (tx_data),
        .tx_valid  (tx_valid),
        .tx_last   (tx_last),
        .station   (station_addr),
        .done      (done),
        .done_bank (done_bank)
    );

    assign bus_rdata = is_reg ? reg_rdata : mem_rdata;
endmodule

// File: rtl/txb_chk.sv
module txb_chk #(
    parameter int BANK_AW = 9
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_we,
    input logic [BANK_AW:0] bus_addr,
    input logic [7:0]       tx_data,
    input logic             tx_valid,
    input logic             tx_ready,
    input logic             tx_last,
    input logic [47:0]      station_addr,
    input logic             irq,
    input logic             gie,
    input logic [1:0]       busy_v,
    input logic [1:0]       prog_v,
    input logic [1:0]       scr_v
);
    localparam logic [BANK_AW:0] STAT0 = (BANK_AW+1)'(2 ** BANK_AW - 1);
    localparam logic [BANK_AW:0] STAT1 = (BANK_AW+1)'(2 ** (BANK_AW + 1) - 1);

    // R4: a stalled byte is held
    a_r4_hold_while_stalled: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

    // R3: bytes only leave while some buffer is busy
    a_r3_stream_needs_busy: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> (busy_v != 2'b00));

    // R10: no interrupt without the global enable
    a_r10_irq_needs_gie: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(gie));

    // R10: interrupt follows a falling busy bit
    a_r10_irq_after_done: assert property (@(posedge clk) disable iff (rst)
        irq |-> ($countones($past(busy_v)) > $countones(busy_v)) || ($past(busy_v) != busy_v));

    // R9: hardware never alters scratch bits
    a_r9_scratch0_hw_stable: assert property (@(posedge clk) disable iff (rst)
        !(bus_we && bus_addr == STAT0) |=> $stable(scr_v[0]));
    a_r9_scratch1_hw_stable: assert property (@(posedge clk) disable iff (rst)
        !(bus_we && bus_addr == STAT1) |=> $stable(scr_v[1]));

    // R7: station address moves only during a load command
    a_r7_station_only_on_load: assert property (@(posedge clk) disable iff (rst)
        (station_addr != $past(station_addr)) |-> ($past(prog_v) != 2'b00));
endmodule

bind txb_ctrl txb_chk #(.BANK_AW(BANK_AW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .bus_we       (bus_we),
    .bus_addr     (bus_addr),
    .tx_data      (tx_data),
    .tx_valid     (tx_valid),
    .tx_ready     (tx_ready),
    .tx_last      (tx_last),
    .station_addr (station_addr),
    .irq          (irq),
    .gie          (gie),
    .busy_v       (busy_v),
    .prog_v       (prog_v),
    .scr_v        (scr_v)
);

// File: tb/txb_ctrl_tb.sv
`timescale 1ns/1ps
module txb_ctrl_tb_top;
    localparam int LEN_W = 509;
    localparam int GIE_W = 510;
    localparam int ST_W  = 511;
    localparam int CAPB  = 2036;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  tx_data;
    logic        tx_valid;
    logic        tx_ready = 1'b0;
    logic        tx_last;
    logic [47:0] station_addr;
    logic        irq;

    int checks = 0;
    int fails = 0;
    int irq_cnt = 0;
    int irq_wide = 0;
    int hold_err = 0;
    int rdy_mode = 0;
    logic [31:0] sh [2][512];
    logic [8:0]  rx_q [$];

    always #2.5 clk = ~clk;

    txb_ctrl dut_i (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_data(tx_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_last(tx_last),
        .station_addr(station_addr), .irq(irq)
    );

    initial forever begin
        @(negedge clk);
        if (rdy_mode == 0)      tx_ready = 1'b0;
        else if (rdy_mode == 1) tx_ready = 1'b1;
        else                    tx_ready = ($urandom % 4) != 0;
    end

    logic       prev_stall = 1'b0;
    logic [8:0] prev_byte = '0;
    logic       prev_irq = 1'b0;
    always @(posedge clk) begin
        if (!rst) begin
            if (prev_stall && !(tx_valid && {tx_last, tx_data} == prev_byte)) hold_err++;
            prev_stall <= tx_valid && !tx_ready;
            prev_byte  <= {tx_last, tx_data};
            if (tx_valid && tx_ready) rx_q.push_back({tx_last, tx_data});
            if (irq) irq_cnt++;
            if (irq && prev_irq) irq_wide++;
            prev_irq <= irq;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int wa(input int bank, input int word);
        return bank * 512 + word;
    endfunction

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a[9:0]; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a[9:0];
        #1 d = bus_rdata;
    endtask

    task automatic wait_idle(input int bank);
        logic [31:0] s;
        s = 32'h1;
        while (s[0]) rd(wa(bank, ST_W), s);
        repeat (3) @(negedge clk);
    endtask

    task automatic fill(input int bank, input int nbytes);
        for (int w = 0; w < (nbytes + 3) / 4; w++) begin
            sh[bank][w] = $urandom;
            wr(wa(bank, w), sh[bank][w]);
        end
    endtask

    function automatic logic [7:0] exp_byte(input int bank, input int i);
        return sh[bank][i / 4][8 * (i % 4) +: 8];
    endfunction

    task automatic check_seg(input int bank, input int n, input string tag);
        int bad;
        bad = 0;
        chk(rx_q.size() >= n, {tag, " byte count"}, rx_q.size(), n);
        for (int i = 0; i < n && rx_q.size() > 0; i++) begin
            logic [8:0] got;
            got = rx_q.pop_front();
            if (got != {(i == n - 1), exp_byte(bank, i)}) begin
                if (bad == 0) chk(0, {tag, " byte/last"}, got, {(i == n - 1), exp_byte(bank, i)});
                bad++;
            end
        end
        if (bad == 0) chk(1, tag, 0, 0);
    endtask

    logic [31:0] v;
    int irq0;

    initial begin
        void'($urandom(32'h5eed_0042));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(wa(0, ST_W), v);  chk(v == 0, "R1 status0", v, 0);
        rd(wa(1, ST_W), v);  chk(v == 0, "R1 status1", v, 0);
        rd(wa(0, LEN_W), v); chk(v == 0, "R1 len0", v, 0);
        rd(wa(0, GIE_W), v); chk(v == 0, "R1 gie", v, 0);
        chk(station_addr == 0 && !irq && !tx_valid, "R1 outputs", {station_addr, irq, tx_valid}, 0);

        // R2 map
        wr(wa(1, 3), 32'hA5A5_5A5A);
        rd(wa(1, 3), v); chk(v == 32'hA5A5_5A5A, "R2 data readback", v, 32'hA5A5_5A5A);
        wr(wa(1, LEN_W), 32'hFFFF_1234);
        rd(wa(1, LEN_W), v); chk(v == 32'h1234, "R2 len width", v, 32'h1234);
        rd(wa(0, LEN_W), v); chk(v == 0, "R2 bank separation", v, 0);
        wr(wa(0, GIE_W), 32'h8000_0000);
        rd(wa(1, GIE_W), v); chk(v == 32'h8000_0000, "R2 shared gie", v, 32'h8000_0000);

        // R3 / R4 / R10 random frames
        rdy_mode = 2;
        for (int it = 0; it < 8; it++) begin
            int bank, n;
            bank = $urandom % 2;
            n = 1 + ($urandom % 80);
            fill(bank, n);
            wr(wa(bank, LEN_W), n);
            irq0 = irq_cnt;
            wr(wa(bank, ST_W), 32'h9);
            wait_idle(bank);
            check_seg(bank, n, "R3 frame");
            chk(irq_cnt == irq0 + 1, "R10 irq on done", irq_cnt, irq0 + 1);
        end

        // R11 status write while busy
        rdy_mode = 0;
        fill(0, 10);
        wr(wa(0, LEN_W), 10);
        wr(wa(0, ST_W), 32'h1);
        repeat (5) @(negedge clk);
        wr(wa(0, ST_W), 32'h0);
        rd(wa(0, ST_W), v); chk(v[0] == 1'b1, "R11 busy not clearable", v, 1);
        wr(wa(0, ST_W), 32'h1);
        rdy_mode = 2;
        wait_idle(0);
        repeat (20) @(negedge clk);
        chk(rx_q.size() == 10, "R11 sent once", rx_q.size(), 10);
        check_seg(0, 10, "R11 frame");

        // R5 ordering
        rdy_mode = 0;
        fill(1, 6);  wr(wa(1, LEN_W), 6);
        fill(0, 9);  wr(wa(0, LEN_W), 9);
        wr(wa(1, ST_W), 32'h1);
        repeat (3) @(negedge clk);
        wr(wa(0, ST_W), 32'h1);
        rdy_mode = 2;
        wait_idle(1);
        wait_idle(0);
        check_seg(1, 6, "R5 first buffer");
        check_seg(0, 9, "R5 second buffer");

        // R6 clamp and zero length
        rdy_mode = 1;
        fill(0, CAPB);
        wr(wa(0, LEN_W), 3000);
        wr(wa(0, ST_W), 32'h1);
        wait_idle(0);
        check_seg(0, CAPB, "R6 clamp");
        chk(rx_q.size() == 0, "R6 no extra bytes", rx_q.size(), 0);
        wr(wa(1, LEN_W), 0);
        irq0 = irq_cnt;
        wr(wa(1, ST_W), 32'h9);
        wait_idle(1);
        chk(rx_q.size() == 0, "R6 zero length", rx_q.size(), 0);
        chk(irq_cnt == irq0 + 1, "R10 zero length irq", irq_cnt, irq0 + 1);

        // R7 station address load
        wr(wa(0, 0), 32'h4433_2211);
        wr(wa(0, 1), 32'h0000_6655);
        wr(wa(0, ST_W), 32'h3);
        wait_idle(0);
        chk(station_addr == 48'h1122_3344_5566, "R7 station value", station_addr, 48'h1122_3344_5566);
        chk(rx_q.size() == 0, "R7 nothing streamed", rx_q.size(), 0);
        rd(wa(0, ST_W), v); chk(v[1:0] == 2'b00, "R7 bits cleared", v, 0);

        // R8 bit 1 alone
        wr(wa(1, ST_W), 32'h2);
        repeat (10) @(negedge clk);
        rd(wa(1, ST_W), v); chk(v == 0, "R8 ignored", v, 0);
        chk(rx_q.size() == 0, "R8 nothing streamed", rx_q.size(), 0);

        // R9 scratch bit
        fill(1, 3); wr(wa(1, LEN_W), 3);
        wr(wa(1, ST_W), 32'h8000_0009);
        wait_idle(1);
        rd(wa(1, ST_W), v); chk(v == 32'h8000_0008, "R9 scratch kept", v, 32'h8000_0008);
        check_seg(1, 3, "R9 frame");

        // R10 gating
        wr(wa(0, GIE_W), 0);
        fill(0, 4); wr(wa(0, LEN_W), 4);
        irq0 = irq_cnt;
        wr(wa(0, ST_W), 32'h9);
        wait_idle(0);
        chk(irq_cnt == irq0, "R10 gie off", irq_cnt, irq0);
        check_seg(0, 4, "R10 frame a");
        wr(wa(0, GIE_W), 32'h8000_0000);
        wr(wa(0, ST_W), 32'h1);
        wait_idle(0);
        chk(irq_cnt == irq0, "R10 ie off", irq_cnt, irq0);
        check_seg(0, 4, "R10 frame b");
        chk(irq_wide == 0, "R10 pulse width", irq_wide, 0);
        chk(hold_err == 0, "R4 hold under stall", hold_err, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule